// File: doc/BRIEF.md
# FIFO Threshold Interrupt Unit

This block sits between a serial shift engine and a register interface. It holds two 256-entry FIFOs. The transmit FIFO is filled from the bus side and drained by the shift engine. The receive FIFO is filled by the shift engine and drained from the bus side. From the fill levels it builds five status flags and four interrupt sources. The sources are a low-water transmit request, a high-water receive request, a sticky receive-overflow error and a sticky receive-idle timeout.

Software selects each watermark with a 3-bit logarithmic code. It masks sources with a mask word that disables a source when the bit is 1. The two sticky errors are cleared through a two-bit write-one-to-clear port. A single interrupt line is the OR of the enabled sources. The shift engine supplies a one-cycle strobe per serial bit period, and the idle timeout counts those strobes.

Both FIFOs read first-word-fall-through. The pop data port shows the head word while the FIFO holds data and shows zero while it is empty. A push and a pop may occur in the same cycle.

Top module: `fifo_thresh_irq`

## Requirements
- R1: After reset both FIFOs are empty, `status_flags` is 5'b00011 and `raw_status` is 4'b1000.
- R2: Each FIFO returns words in push order. `*_pop_data` is the head word, or zero when the FIFO is empty. A pop from an empty FIFO changes nothing. A push into a full transmit FIFO without a pop in the same cycle is dropped. When a push and a pop occur in the same cycle and the FIFO is not empty, both take effect.
- R3: `status_flags` has five bits: bit0 transmit empty, bit1 transmit not full, bit2 receive not empty, bit3 receive full, bit4 busy. Busy is high when `shift_active` is high or the transmit FIFO holds data.
- R4: A level code maps to a count. Code 0 gives 1, code 1 gives 4, code 2 gives 8, code 3 gives 16, code 4 gives 32, code 5 gives 64, and codes 6 and 7 both give 128.
- R5: `raw_status` bit3 (transmit) is high exactly while the transmit fill level is at or below the count selected by `tx_lvl_code`.
- R6: `raw_status` bit2 (receive) is high exactly while the receive fill level is at or above the count selected by `rx_lvl_code`.
- R7: `raw_status` bit0 (overflow) is set when a receive push arrives while the receive FIFO is full and no receive pop occurs in the same cycle. The pushed word is discarded. The bit stays set until it is cleared.
- R8: `raw_status` bit1 (timeout) is set when the receive FIFO is non-empty and 32 `bit_tick` strobes arrive with no receive push or pop. The flag appears in the cycle after the 32nd strobe. Strobes are not counted while the FIFO is empty. Any receive push or pop restarts the count. After a timeout, no further timeout is raised until a push or pop occurs.
- R9: A cycle with `clr_wr` high clears bit0 when `clr_bits[0]` is 1 and clears bit1 when `clr_bits[1]` is 1. A set event in the same cycle wins over the clear.
- R10: `masked_status` equals `raw_status & ~irq_mask`, and `irq` is the OR of `masked_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One strobe per serial bit period |
| shift_active | input | 1 | Shift engine is mid-frame |
| tx_push | input | 1 | Write a word into the transmit FIFO |
| tx_push_data | input | DATA_W | Transmit word |
| tx_pop | input | 1 | Shift engine takes the head transmit word |
| tx_pop_data | output | DATA_W | Head of the transmit FIFO, or zero when empty |
| rx_push | input | 1 | Shift engine stores a received word |
| rx_push_data | input | DATA_W | Received word |
| rx_pop | input | 1 | Bus side takes the head receive word |
| rx_pop_data | output | DATA_W | Head of the receive FIFO, or zero when empty |
| tx_lvl_code | input | 3 | Transmit watermark code |
| rx_lvl_code | input | 3 | Receive watermark code |
| irq_mask | input | 4 | 1 disables the corresponding source |
| clr_wr | input | 1 | Clear strobe |
| clr_bits | input | 2 | Write-one-to-clear: bit0 overflow, bit1 timeout |
| status_flags | output | 5 | FIFO and busy flags |
| raw_status | output | 4 | Unmasked interrupt sources |
| masked_status | output | 4 | Enabled interrupt sources |
| irq | output | 1 | Interrupt request |

## Verification
Each watermark code is tested at its exact count and at one entry past it. A design with an off-by-one compare, or with a wrong decode for code 0 or code 7, flips the source bit at one of these two points.

Both FIFOs are filled to 256 entries and then given one more push. A design that wraps its pointer would return the extra word or lose the oldest one. A design that forgets the overflow flag, or lets the clear of a neighbouring bit touch it, is also exposed.

The idle timer is probed after 31 and after 32 strobes, while the FIFO is empty, after a timeout has already fired, and with a clear in the same cycle as the set. These cases catch counting while empty, a wrong terminal count, retriggering, and a clear that beats the set.

A long random run with shifting watermarks, masks and clears is compared against queue models. It catches errors in simultaneous push and pop at full or empty and in the zero returned by an empty pop.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned SRC_OV = 0;
  localparam int unsigned SRC_TO = 1;
  localparam int unsigned SRC_RX = 2;
  localparam int unsigned SRC_TX = 3;

  localparam int unsigned NFLAG   = 5;
  localparam int unsigned FL_TXE  = 0;
  localparam int unsigned FL_TXNF = 1;
  localparam int unsigned FL_RXNE = 2;
  localparam int unsigned FL_RXF  = 3;
  localparam int unsigned FL_BUSY = 4;

  localparam int unsigned LVL_CODE_W = 3;

  // Logarithmic watermark decode: 0 -> 1, k in 1..5 -> 2^(k+1), 6 and 7 -> 128.
  function automatic logic [7:0] lvl_decode(input logic [LVL_CODE_W-1:0] code);
    logic [7:0] r;
    if (code == 3'd0)       r = 8'd1;
    else if (code >= 3'd6)  r = 8'd128;
    else                    r = 8'd1 << (code + 3'd1);
    return r;
  endfunction
endpackage

// File: rtl/fiu_fifo.sv
module fiu_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok, push_ok;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign pop_ok    = pop && !empty;
  assign push_ok   = push && (!full || pop_ok);
  assign push_drop = push && !push_ok;
  assign pop_data  = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_empty_pop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
  assert_drop_keeps_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> full);
endmodule

// File: rtl/fiu_idle_timer.sv
module fiu_idle_timer #(
  parameter int unsigned LIMIT = 32,
  localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic activity,
  input  logic nonempty,
  output logic expire
);
  logic [TW-1:0] cnt;

  assign expire = nonempty && !activity && tick && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (!nonempty || activity)   cnt <= '0;
    else if (tick && cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assert_expire_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == TW'(LIMIT)) && !expire);
  assert_no_count_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nonempty |=> cnt == '0);
endmodule

// File: rtl/fiu_irq_status.sv
module fiu_irq_status
  import fiu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovf_evt,
  input  logic            to_evt,
  input  logic            rx_hit,
  input  logic            tx_hit,
  input  logic            clr_wr,
  input  logic [1:0]      clr_bits,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] masked,
  output logic            irq
);
  logic ovf_q, to_q;
  logic clr_ov, clr_to;

  assign clr_ov = clr_wr && clr_bits[0];
  assign clr_to = clr_wr && clr_bits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (ovf_evt)     ovf_q <= 1'b1;
      else if (clr_ov) ovf_q <= 1'b0;
      if (to_evt)      to_q  <= 1'b1;
      else if (clr_to) to_q  <= 1'b0;
    end
  end

  always_comb begin
    raw         = '0;
    raw[SRC_OV] = ovf_q;
    raw[SRC_TO] = to_q;
    raw[SRC_RX] = rx_hit;
    raw[SRC_TX] = tx_hit;
  end

  assign masked = raw & ~mask;
  assign irq    = |masked;

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[SRC_OV] && !clr_ov) |=> raw[SRC_OV]);
  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_to && !to_evt) |=> !raw[SRC_TO]);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && clr_ov) |=> raw[SRC_OV]);
endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
  import fiu_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 256,
  parameter int unsigned IDLE_BITS  = 32,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_tick,
  input  logic                  shift_active,
  input  logic                  tx_push,
  input  logic [DATA_W-1:0]     tx_push_data,
  input  logic                  tx_pop,
  output logic [DATA_W-1:0]     tx_pop_data,
  input  logic                  rx_push,
  input  logic [DATA_W-1:0]     rx_push_data,
  input  logic                  rx_pop,
  output logic [DATA_W-1:0]     rx_pop_data,
  input  logic [LVL_CODE_W-1:0] tx_lvl_code,
  input  logic [LVL_CODE_W-1:0] rx_lvl_code,
  input  logic [NSRC-1:0]       irq_mask,
  input  logic                  clr_wr,
  input  logic [1:0]            clr_bits,
  output logic [NFLAG-1:0]      status_flags,
  output logic [NSRC-1:0]       raw_status,
  output logic [NSRC-1:0]       masked_status,
  output logic                  irq
);
  logic [CW-1:0] tx_count, rx_count, tx_thr, rx_thr;
  logic tx_full, tx_empty, tx_drop;
  logic rx_full, rx_empty, rx_drop;
  logic tx_hit, rx_hit, idle_expire, rx_activity;

  fiu_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk, .rst_n,
    .push(tx_push), .push_data(tx_push_data),
    .pop(tx_pop), .pop_data(tx_pop_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty), .push_drop(tx_drop)
  );

  fiu_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk, .rst_n,
    .push(rx_push), .push_data(rx_push_data),
    .pop(rx_pop), .pop_data(rx_pop_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty), .push_drop(rx_drop)
  );

  assign tx_thr = CW'(lvl_decode(tx_lvl_code));
  assign rx_thr = CW'(lvl_decode(rx_lvl_code));
  assign tx_hit = (tx_count <= tx_thr);
  assign rx_hit = (rx_count >= rx_thr);

  assign rx_activity = rx_push || rx_pop;

  fiu_idle_timer #(.LIMIT(IDLE_BITS)) u_idle (
    .clk, .rst_n,
    .tick(bit_tick), .activity(rx_activity), .nonempty(!rx_empty),
    .expire(idle_expire)
  );

  fiu_irq_status u_status (
    .clk, .rst_n,
    .ovf_evt(rx_drop), .to_evt(idle_expire),
    .rx_hit, .tx_hit,
    .clr_wr, .clr_bits, .mask(irq_mask),
    .raw(raw_status), .masked(masked_status), .irq
  );

  always_comb begin
    status_flags          = '0;
    status_flags[FL_TXE]  = tx_empty;
    status_flags[FL_TXNF] = !tx_full;
    status_flags[FL_RXNE] = !rx_empty;
    status_flags[FL_RXF]  = rx_full;
    status_flags[FL_BUSY] = shift_active || !tx_empty;
  end

  assert_tx_src_at_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[FL_TXE] |-> raw_status[SRC_TX]);
  assert_rx_src_at_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[FL_RXF] |-> raw_status[SRC_RX]);
  assert_ovf_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> raw_status[SRC_OV]);
  assert_tx_drop_stays_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> !status_flags[FL_TXNF]);
  assert_full_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '1) |-> !irq);
  assert_busy_when_tx_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !status_flags[FL_TXE] |-> status_flags[FL_BUSY]);
endmodule

// File: tb/fifo_thresh_irq_tb_top.sv
module fifo_thresh_irq_tb_top;
  localparam int DW = 16;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, bit_tick, shift_active;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [DW-1:0] tx_push_data, rx_push_data, tx_pop_data, rx_pop_data;
  logic [2:0] tx_lvl_code, rx_lvl_code;
  logic [3:0] irq_mask, raw_status, masked_status;
  logic clr_wr;
  logic [1:0] clr_bits;
  logic [4:0] status_flags;
  logic irq;

  fifo_thresh_irq dut_i (
    .clk, .rst_n, .bit_tick, .shift_active,
    .tx_push, .tx_push_data, .tx_pop, .tx_pop_data,
    .rx_push, .rx_push_data, .rx_pop, .rx_pop_data,
    .tx_lvl_code, .rx_lvl_code, .irq_mask, .clr_wr, .clr_bits,
    .status_flags, .raw_status, .masked_status, .irq
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic int exp_thr(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 32;
      5: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tx_put(input logic [DW-1:0] v);
    tx_push = 1'b1; tx_push_data = v; cyc(); tx_push = 1'b0;
  endtask
  task automatic rx_put(input logic [DW-1:0] v);
    rx_push = 1'b1; rx_push_data = v; cyc(); rx_push = 1'b0;
  endtask
  task automatic tx_take(output logic [DW-1:0] v);
    v = tx_pop_data; tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
  endtask
  task automatic rx_take(output logic [DW-1:0] v);
    v = rx_pop_data; rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
  endtask
  task automatic ticks(input int n);
    bit_tick = 1'b1; repeat (n) cyc(); bit_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];
    bit ovf_m;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bit_tick = 0; shift_active = 0;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_push_data = '0; rx_push_data = '0;
    tx_lvl_code = 3'd0; rx_lvl_code = 3'd0; irq_mask = 4'h0;
    clr_wr = 0; clr_bits = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(status_flags == 5'b00011, "R1 flags", status_flags, 5'b00011);
    chk(raw_status == 4'b1000, "R1 raw", raw_status, 4'b1000);
    chk(irq == 1'b1, "R1 R10 irq", irq, 1);

    // R4 R5 transmit watermark at exact count and one beyond
    for (int c = 0; c < 8; c++) begin
      int t;
      t = exp_thr(c);
      tx_lvl_code = 3'(c);
      for (int k = 0; k < t; k++) tx_put(DW'(k));
      chk(raw_status[3] == 1'b1, "R4 R5 tx at level", raw_status[3], 1);
      tx_put(16'h00FF);
      chk(raw_status[3] == 1'b0, "R4 R5 tx above level", raw_status[3], 0);
      for (int k = 0; k <= t; k++) tx_take(v);
    end

    // R4 R6 receive watermark one below and at count
    for (int c = 0; c < 8; c++) begin
      int t;
      t = exp_thr(c);
      rx_lvl_code = 3'(c);
      for (int k = 0; k < t - 1; k++) rx_put(DW'(k));
      chk(raw_status[2] == 1'b0, "R4 R6 rx below level", raw_status[2], 0);
      rx_put(16'h0077);
      chk(raw_status[2] == 1'b1, "R4 R6 rx at level", raw_status[2], 1);
      for (int k = 0; k < t; k++) rx_take(v);
    end
    chk(raw_status[0] == 1'b0, "R7 no spurious overflow", raw_status[0], 0);

    // R2 empty pop returns zero and leaves pointers
    chk(tx_pop_data == '0, "R2 empty head zero", tx_pop_data, 0);
    tx_take(v);
    chk(status_flags[0] == 1'b1, "R2 empty pop stays empty", status_flags[0], 1);
    tx_put(16'hA5A5);
    chk(tx_pop_data == 16'hA5A5, "R2 head after empty pop", tx_pop_data, 16'hA5A5);
    chk(status_flags[4] == 1'b1, "R3 busy from tx data", status_flags[4], 1);
    tx_take(v);
    shift_active = 1'b1;
    #1;
    chk(status_flags == 5'b10011, "R3 busy from shift", status_flags, 5'b10011);
    shift_active = 1'b0;

    // R2 transmit fill to full, extra push dropped, order kept
    for (int k = 0; k < DEPTH; k++) tx_put(DW'(16'h1000 + k));
    chk(status_flags[1:0] == 2'b00, "R2 R3 tx full flags", status_flags[1:0], 0);
    tx_put(16'hBEEF);
    begin
      bit order_ok;
      order_ok = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
        tx_take(v);
        if (v != DW'(16'h1000 + k)) order_ok = 1'b0;
      end
      chk(order_ok, "R2 tx order and drop", order_ok, 1);
    end
    chk(status_flags[0] == 1'b1, "R2 tx drained", status_flags[0], 1);

    // R7 receive overflow
    for (int k = 0; k < DEPTH; k++) rx_put(DW'(16'h2000 + k));
    chk(status_flags[3:2] == 2'b11, "R3 rx full flags", status_flags[3:2], 3);
    chk(raw_status[0] == 1'b0, "R7 full not overflow", raw_status[0], 0);
    rx_put(16'hDEAD);
    chk(raw_status[0] == 1'b1, "R7 overflow set", raw_status[0], 1);
    begin
      bit order_ok;
      order_ok = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
        rx_take(v);
        if (v != DW'(16'h2000 + k)) order_ok = 1'b0;
      end
      chk(order_ok, "R7 overflow word discarded", order_ok, 1);
    end
    chk(raw_status[0] == 1'b1, "R7 overflow sticky", raw_status[0], 1);
    clr_wr = 1'b1; clr_bits = 2'b10; cyc(); clr_wr = 1'b0;
    chk(raw_status[0] == 1'b1, "R9 other clear bit ignored", raw_status[0], 1);

    // R10 masking with raw = overflow + tx level
    irq_mask = 4'b0001;
    #1;
    chk(masked_status == 4'b1000, "R10 masked", masked_status, 4'b1000);
    irq_mask = 4'b1000;
    #1;
    chk(masked_status == 4'b0001 && irq, "R10 masked tx", masked_status, 4'b0001);
    irq_mask = 4'b1001;
    #1;
    chk(irq == 1'b0, "R10 all enabled sources masked", irq, 0);
    irq_mask = 4'b0000;
    clr_wr = 1'b1; clr_bits = 2'b01; cyc(); clr_wr = 1'b0;
    chk(raw_status[0] == 1'b0, "R9 overflow cleared", raw_status[0], 0);

    // R8 idle timeout
    ticks(40);
    chk(raw_status[1] == 1'b0, "R8 no count while empty", raw_status[1], 0);
    rx_put(16'h0001);
    ticks(31);
    chk(raw_status[1] == 1'b0, "R8 31 strobes", raw_status[1], 0);
    ticks(1);
    chk(raw_status[1] == 1'b1, "R8 32 strobes", raw_status[1], 1);
    clr_wr = 1'b1; clr_bits = 2'b10; cyc(); clr_wr = 1'b0;
    chk(raw_status[1] == 1'b0, "R9 timeout cleared", raw_status[1], 0);
    ticks(40);
    chk(raw_status[1] == 1'b0, "R8 no retrigger", raw_status[1], 0);
    ticks(20);
    rx_put(16'h0002);
    ticks(31);
    chk(raw_status[1] == 1'b0, "R8 restart on push", raw_status[1], 0);
    bit_tick = 1'b1; clr_wr = 1'b1; clr_bits = 2'b10; cyc();
    bit_tick = 1'b0; clr_wr = 1'b0;
    chk(raw_status[1] == 1'b1, "R9 set wins over clear", raw_status[1], 1);
    rx_take(v);
    rx_take(v);
    clr_wr = 1'b1; clr_bits = 2'b11; cyc(); clr_wr = 1'b0;
    chk(raw_status[1:0] == 2'b00, "R9 both cleared", raw_status[1:0], 0);

    // Random run against queue models
    ovf_m = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bit ph, tpo, rpo, tpu, rpu;
      logic [3:0] exp_raw;
      logic [4:0] exp_fl;
      logic [DW-1:0] ehead;
      ph = ((i / 500) % 2) == 1;
      tx_push = ($urandom % 100) < (ph ? 30 : 75);
      tx_pop  = ($urandom % 100) < (ph ? 75 : 30);
      rx_push = ($urandom % 100) < (ph ? 30 : 75);
      rx_pop  = ($urandom % 100) < (ph ? 75 : 30);
      tx_push_data = DW'($urandom);
      rx_push_data = DW'($urandom);
      shift_active = $urandom % 2;
      if ($urandom % 16 == 0) tx_lvl_code = 3'($urandom % 8);
      if ($urandom % 16 == 0) rx_lvl_code = 3'($urandom % 8);
      if ($urandom % 32 == 0) irq_mask = 4'($urandom % 16);
      clr_wr = ($urandom % 40) == 0;
      clr_bits = 2'($urandom % 4);
      #1;
      ehead = (txq.size() > 0) ? txq[0] : '0;
      chk(tx_pop_data == ehead, "R2 random tx head", tx_pop_data, ehead);
      ehead = (rxq.size() > 0) ? rxq[0] : '0;
      chk(rx_pop_data == ehead, "R2 random rx head", rx_pop_data, ehead);
      exp_raw = {txq.size() <= exp_thr(tx_lvl_code), rxq.size() >= exp_thr(rx_lvl_code), 1'b0, ovf_m};
      chk(raw_status == exp_raw, "R5 R6 R7 random raw", raw_status, exp_raw);
      exp_fl = {shift_active || txq.size() != 0, rxq.size() == DEPTH, rxq.size() != 0,
                txq.size() != DEPTH, txq.size() == 0};
      chk(status_flags == exp_fl, "R3 random flags", status_flags, exp_fl);
      chk(masked_status == (exp_raw & ~irq_mask) && irq == |(exp_raw & ~irq_mask),
          "R10 random mask", {irq, masked_status}, {|(exp_raw & ~irq_mask), exp_raw & ~irq_mask});
      tpo = tx_pop && txq.size() > 0;
      tpu = tx_push && (txq.size() < DEPTH || tpo);
      rpo = rx_pop && rxq.size() > 0;
      rpu = rx_push && (rxq.size() < DEPTH || rpo);
      if (tpo) void'(txq.pop_front());
      if (tpu) txq.push_back(tx_push_data);
      if (rpo) void'(rxq.pop_front());
      if (rpu) rxq.push_back(rx_push_data);
      if (rx_push && !rpu) ovf_m = 1'b1;
      else if (clr_wr && clr_bits[0]) ovf_m = 1'b0;
      cyc();
    end
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; clr_wr = 0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule